// File: doc/BRIEF.md
# Ping-Pong DMA Channel Controller

This block holds the control and status state of a single DMA channel that works through two memory buffers in turn. Software programs a start pointer and a byte count for each buffer, arms either buffer with its own start bit, and opens the channel with a run bit. The controller then issues bursts against the buffer selected by its buffer-select flag. When that buffer's count runs out, the controller flags it complete and flips the flag. If the other buffer is already armed, it continues there without a gap. If not, it waits for software to arm it.

Software can pause the channel by dropping the run bit. A burst already on the bus is allowed to finish, and the channel later resumes from the saved pointer of the same buffer. A memory error freezes the channel and leaves the pointers where they were until software raises run again. One interrupt line reports completions and errors, gated by an enable bit. Bursts are issued only while the peripheral's request input is high.

Top module: `pp_dma_ctrl`

## Requirements
- R1: Register offsets are 0 for the control word, 1 for the device address, 2 and 3 for buffer A's pointer and count, and 4 and 5 for buffer B's pointer and count. The control-word bits are: bit 0 run, bit 1 interrupt enable, bit 2 error, bit 3 A done, bit 4 A start, bit 5 B done, bit 6 B start, and bit 7 buffer select (0 = A, 1 = B). Bits 31..8 read as zero and ignore writes. Every field resets to 0.
- R2: No burst is issued while run is 0. A start bit written by a control-word write that leaves run at 0 is ignored.
- R3: Clearing run while a burst is outstanding keeps the request and address steady until that burst is acknowledged. After that no further burst is issued. Setting run again resumes from the saved pointer of the same buffer.
- R4: The device-address register takes a write only while run is 0. Writes made while run is 1 leave it unchanged. Its value drives `mem_dev`.
- R5: `irq` equals interrupt enable AND (A done OR B done OR error).
- R6: `mem_err` on an outstanding burst sets error, stops further bursts, and leaves that buffer's pointer and count unchanged. A control-word write with bit 0 set clears error, and bursts then resume from the unchanged pointer.
- R7: Writing 1 to a done bit clears it. Arming a buffer through its start bit also clears that buffer's done bit. Writing 0 to a done bit leaves it as it is.
- R8: A burst presents the active pointer on `mem_addr` and min(count, BURST_BYTES) on `mem_len`. On acknowledge, the pointer grows by that length and the count shrinks by it. When the count reaches zero, that buffer's done bit sets and the buffer select toggles.
- R9: Only the buffer named by buffer select is started. When it completes and the other buffer is armed with run at 1, the first burst of the other buffer follows the last acknowledge two cycles later, the same spacing as between bursts within a buffer. Otherwise the channel waits.
- R10: A start bit reads 1 while its buffer waits to begin and clears itself when that buffer's transfer starts.
- R11: Bursts are issued only while `dreq` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| dreq | input | 1 | Peripheral request; a burst may start only while high |
| mem_req | output | 1 | Burst outstanding |
| mem_addr | output | MEM_AW | Burst start address |
| mem_len | output | CNT_W | Burst length in bytes |
| mem_dev | output | DEV_W | Device address for the peripheral side |
| mem_ack | input | 1 | Burst completed |
| mem_err | input | 1 | Burst failed |
| irq | output | 1 | Interrupt request |

## Verification
The in-RTL properties assume that `mem_ack` and `mem_err` are asserted only while `mem_req` is high. They also assume that an error response takes precedence if both arrive together. The bench meets this by forming both responses as `mem_req` ANDed with bench enables, so a response can never arrive without an outstanding burst. Register writes are spaced one per cycle and driven between clock edges. The tests vary `dreq`, the run bit and the start bits freely, because the design must tolerate any pattern on those.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;

    // Control-word bit positions (software decodes these).
    localparam int CW_RUN    = 0;
    localparam int CW_IE     = 1;
    localparam int CW_ERR    = 2;
    localparam int CW_DONE_A = 3;
    localparam int CW_STRT_A = 4;
    localparam int CW_DONE_B = 5;
    localparam int CW_STRT_B = 6;
    localparam int CW_BSEL   = 7;

    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        RA_CTL   = 3'd0,
        RA_DEV   = 3'd1,
        RA_PTR_A = 3'd2,
        RA_CNT_A = 3'd3,
        RA_PTR_B = 3'd4,
        RA_CNT_B = 3'd5
    } reg_addr_e;

    typedef enum logic {
        SQ_IDLE  = 1'b0,
        SQ_BURST = 1'b1
    } seq_state_e;

    // Channel control/status state; index 0 = buffer A, 1 = buffer B.
    typedef struct packed {
        logic       bsel;
        logic [1:0] strt;
        logic [1:0] done;
        logic       err;
        logic       ie;
        logic       run;
    } chan_ctl_t;

    // Per-cycle events raised by the sequencer towards the control word.
    typedef struct packed {
        logic       set_err;
        logic [1:0] done_set;
        logic [1:0] strt_clr;
    } seq_evt_t;

    function automatic logic [31:0] pack_ctl(input chan_ctl_t c);
        logic [31:0] w;
        w = '0;
        w[CW_RUN]    = c.run;
        w[CW_IE]     = c.ie;
        w[CW_ERR]    = c.err;
        w[CW_DONE_A] = c.done[0];
        w[CW_STRT_A] = c.strt[0];
        w[CW_DONE_B] = c.done[1];
        w[CW_STRT_B] = c.strt[1];
        w[CW_BSEL]   = c.bsel;
        return w;
    endfunction

endpackage

// File: rtl/pp_dma_ctl.sv
module pp_dma_ctl
    import pp_dma_pkg::*;
#(
    parameter int DEV_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_we,
    input  logic             dev_we,
    input  logic [7:0]       ctl_wdata,
    input  logic [DEV_W-1:0] dev_wdata,
    input  seq_evt_t         evt,
    output chan_ctl_t        ctl_q,
    output logic [DEV_W-1:0] dev_q
);

    chan_ctl_t  ctl_n;
    logic       w_run;
    logic [1:0] w_strt;
    logic [1:0] w_dclr;

    assign w_run  = ctl_wdata[CW_RUN];
    assign w_strt = {ctl_wdata[CW_STRT_B], ctl_wdata[CW_STRT_A]};
    assign w_dclr = {ctl_wdata[CW_DONE_B], ctl_wdata[CW_DONE_A]};

    always_comb begin
        ctl_n      = ctl_q;
        // hardware clears of start bits first, software arming may re-set
        ctl_n.strt = ctl_q.strt & ~evt.strt_clr;
        if (ctl_we) begin
            ctl_n.run  = w_run;
            ctl_n.ie   = ctl_wdata[CW_IE];
            ctl_n.done = ctl_n.done & ~w_dclr;
            if (w_run) begin
                ctl_n.err  = 1'b0;
                ctl_n.strt = ctl_n.strt | w_strt;
                ctl_n.done = ctl_n.done & ~w_strt;
            end
        end
        // hardware status sets take priority over software clears
        ctl_n.done = ctl_n.done | evt.done_set;
        ctl_n.err  = ctl_n.err | evt.set_err;
        ctl_n.bsel = ctl_q.bsel ^ (|evt.done_set);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            dev_q <= '0;
        end else begin
            ctl_q <= ctl_n;
            if (dev_we && !ctl_q.run) begin
                dev_q <= dev_wdata;
            end
        end
    end

    // R4: device address frozen while the channel runs
    p_dev_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        ctl_q.run |=> $stable(dev_q))
        else $error("device address changed while running");

endmodule

// File: rtl/pp_dma_bufregs.sv
module pp_dma_bufregs #(
    parameter int MEM_AW = 32,
    parameter int CNT_W  = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [1:0]             ptr_we,
    input  logic [1:0]             cnt_we,
    input  logic [31:0]            wdata,
    input  logic                   adv,
    input  logic                   adv_sel,
    input  logic [CNT_W-1:0]       adv_len,
    output logic [1:0][MEM_AW-1:0] ptr_o,
    output logic [1:0][CNT_W-1:0]  cnt_o
);

    localparam int NBUF = 2;

    for (genvar g = 0; g < NBUF; g++) begin : g_buf
        logic [MEM_AW-1:0] ptr_q;
        logic [CNT_W-1:0]  cnt_q;
        logic              hit;

        assign hit = adv && (adv_sel == 1'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                ptr_q <= '0;
                cnt_q <= '0;
            end else begin
                if (ptr_we[g]) begin
                    ptr_q <= wdata[MEM_AW-1:0];
                end else if (hit) begin
                    ptr_q <= ptr_q + MEM_AW'(adv_len);
                end
                if (cnt_we[g]) begin
                    cnt_q <= wdata[CNT_W-1:0];
                end else if (hit) begin
                    cnt_q <= cnt_q - adv_len;
                end
            end
        end

        assign ptr_o[g] = ptr_q;
        assign cnt_o[g] = cnt_q;
    end

endmodule

// File: rtl/pp_dma_seq.sv
module pp_dma_seq
    import pp_dma_pkg::*;
#(
    parameter int MEM_AW      = 32,
    parameter int CNT_W       = 16,
    parameter int BURST_BYTES = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  chan_ctl_t              ctl,
    input  logic                   dreq,
    input  logic                   mem_ack_i,
    input  logic                   mem_err_i,
    input  logic [1:0][MEM_AW-1:0] ptr,
    input  logic [1:0][CNT_W-1:0]  cnt,
    output logic                   mem_req_o,
    output logic [MEM_AW-1:0]      mem_addr_o,
    output logic [CNT_W-1:0]       mem_len_o,
    output logic                   adv,
    output seq_evt_t               evt
);

    localparam logic [CNT_W-1:0] BLEN = CNT_W'(BURST_BYTES);

    seq_state_e       state_q, state_n;
    logic             busy_q, busy_n;   // a buffer transfer is under way
    logic             cur, oth;
    logic [CNT_W-1:0] cur_cnt, blen, remain;
    logic             begin_go, finish, issue, chain;

    assign cur     = ctl.bsel;
    assign oth     = ~ctl.bsel;
    assign cur_cnt = cnt[cur];
    assign blen    = (cur_cnt < BLEN) ? cur_cnt : BLEN;
    assign remain  = cur_cnt - blen;

    always_comb begin
        begin_go    = 1'b0;
        finish      = 1'b0;
        issue       = 1'b0;
        adv         = 1'b0;
        evt.set_err = 1'b0;
        unique case (state_q)
            SQ_IDLE: begin
                if (!busy_q) begin
                    begin_go = ctl.run && !ctl.err && ctl.strt[cur];
                end else if (cur_cnt == '0) begin
                    finish = 1'b1;
                end else begin
                    issue = ctl.run && !ctl.err && dreq;
                end
            end
            SQ_BURST: begin
                if (mem_err_i) begin
                    evt.set_err = 1'b1;
                end else if (mem_ack_i) begin
                    adv    = 1'b1;
                    finish = (remain == '0);
                end
            end
            default: ;
        endcase

        chain = finish && ctl.run && !ctl.err && ctl.strt[oth];

        evt.done_set = '0;
        evt.strt_clr = '0;
        if (finish)   evt.done_set[cur] = 1'b1;
        if (begin_go) evt.strt_clr[cur] = 1'b1;
        if (chain)    evt.strt_clr[oth] = 1'b1;

        state_n = state_q;
        if (state_q == SQ_IDLE && issue) begin
            state_n = SQ_BURST;
        end else if (state_q == SQ_BURST && (mem_ack_i || mem_err_i)) begin
            state_n = SQ_IDLE;
        end

        busy_n = busy_q;
        if (begin_go) busy_n = 1'b1;
        if (finish)   busy_n = chain;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            busy_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            busy_q  <= busy_n;
        end
    end

    assign mem_req_o  = (state_q == SQ_BURST);
    assign mem_addr_o = ptr[cur];
    assign mem_len_o  = blen;

    // R3: an outstanding burst holds until a response arrives
    p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_ack_i && !mem_err_i) |=> mem_req_o)
        else $error("burst request dropped without a response");

    // R8: the burst address does not move while waiting for a response
    p_addr_steady_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_ack_i && !mem_err_i) |=> $stable(mem_addr_o))
        else $error("burst address moved mid-burst");

    // R2: a new burst only starts after a cycle with run set
    p_issue_run_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req_o) |-> $past(ctl.run))
        else $error("burst issued with run clear");

    // R11: a new burst only starts after a cycle with dreq set
    p_issue_dreq_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req_o) |-> $past(dreq))
        else $error("burst issued without peripheral request");

    // R6: an error response ends issuing
    p_err_stop_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && mem_err_i) |=> !mem_req_o)
        else $error("burst continued after memory error");

endmodule

// File: rtl/pp_dma_ctrl.sv
module pp_dma_ctrl
    import pp_dma_pkg::*;
#(
    parameter int MEM_AW      = 32,
    parameter int CNT_W       = 16,
    parameter int DEV_W       = 32,
    parameter int BURST_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              dreq,
    output logic              mem_req,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [CNT_W-1:0]  mem_len,
    output logic [DEV_W-1:0]  mem_dev,
    input  logic              mem_ack,
    input  logic              mem_err,
    output logic              irq
);

    chan_ctl_t              ctl;
    seq_evt_t               evt;
    logic [1:0][MEM_AW-1:0] ptr;
    logic [1:0][CNT_W-1:0]  cnt;
    logic                   adv;
    logic                   ctl_we, dev_we;
    logic [1:0]             ptr_we, cnt_we;
    reg_addr_e              ra;

    assign ra        = reg_addr_e'(reg_addr);
    assign ctl_we    = reg_we && (ra == RA_CTL);
    assign dev_we    = reg_we && (ra == RA_DEV);
    assign ptr_we[0] = reg_we && (ra == RA_PTR_A);
    assign ptr_we[1] = reg_we && (ra == RA_PTR_B);
    assign cnt_we[0] = reg_we && (ra == RA_CNT_A);
    assign cnt_we[1] = reg_we && (ra == RA_CNT_B);

    pp_dma_ctl #(
        .DEV_W (DEV_W)
    ) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .ctl_we    (ctl_we),
        .dev_we    (dev_we),
        .ctl_wdata (reg_wdata[7:0]),
        .dev_wdata (reg_wdata[DEV_W-1:0]),
        .evt       (evt),
        .ctl_q     (ctl),
        .dev_q     (mem_dev)
    );

    pp_dma_bufregs #(
        .MEM_AW (MEM_AW),
        .CNT_W  (CNT_W)
    ) u_bufregs (
        .clk     (clk),
        .rst     (rst),
        .ptr_we  (ptr_we),
        .cnt_we  (cnt_we),
        .wdata   (reg_wdata),
        .adv     (adv),
        .adv_sel (ctl.bsel),
        .adv_len (mem_len),
        .ptr_o   (ptr),
        .cnt_o   (cnt)
    );

    pp_dma_seq #(
        .MEM_AW      (MEM_AW),
        .CNT_W       (CNT_W),
        .BURST_BYTES (BURST_BYTES)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .dreq       (dreq),
        .mem_ack_i  (mem_ack),
        .mem_err_i  (mem_err),
        .ptr        (ptr),
        .cnt        (cnt),
        .mem_req_o  (mem_req),
        .mem_addr_o (mem_addr),
        .mem_len_o  (mem_len),
        .adv        (adv),
        .evt        (evt)
    );

    always_comb begin
        unique case (ra)
            RA_CTL:   reg_rdata = pack_ctl(ctl);
            RA_DEV:   reg_rdata = 32'(mem_dev);
            RA_PTR_A: reg_rdata = 32'(ptr[0]);
            RA_CNT_A: reg_rdata = 32'(cnt[0]);
            RA_PTR_B: reg_rdata = 32'(ptr[1]);
            RA_CNT_B: reg_rdata = 32'(cnt[1]);
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = ctl.ie && (ctl.err || (|ctl.done));

endmodule

// File: tb/test_pp_dma_ctrl.sv
module test_pp_dma_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        dreq;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [15:0] mem_len;
    logic [31:0] mem_dev;
    logic        mem_ack, mem_err;
    logic        irq;
    logic        ack_en, err_inj;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    logic [31:0] log_addr [64];
    logic [15:0] log_len  [64];
    int          log_cyc  [64];
    int          log_n = 0;

    always #5 clk = ~clk;  // 100 MHz
    always @(posedge clk) cyc <= cyc + 1;

    assign mem_ack = mem_req & ack_en;
    assign mem_err = mem_req & err_inj;

    pp_dma_ctrl i_pp_dma_ctrl (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_len(mem_len),
        .mem_dev(mem_dev), .mem_ack(mem_ack), .mem_err(mem_err), .irq(irq)
    );

    // Record each burst that will be acknowledged at the next edge.
    always begin
        @(negedge clk);
        #2;
        if (!rst && mem_req && mem_ack && !mem_err && log_n < 64) begin
            log_addr[log_n] = mem_addr;
            log_len[log_n]  = mem_len;
            log_cyc[log_n]  = cyc;
            log_n = log_n + 1;
        end
    end

    // Register table: {wr offset, wr data, rd offset, expected read, tag}
    localparam int NVEC = 10;
    localparam logic [73:0] VEC [NVEC] = '{
        {3'd0, 32'hFFFF_FFFE, 3'd0, 32'h0000_0002, 4'd1}, // R1 reserved/readonly bits, R2 start ignored
        {3'd1, 32'h0000_0ABC, 3'd1, 32'h0000_0ABC, 4'd4}, // R4 write while stopped
        {3'd0, 32'h0000_0001, 3'd0, 32'h0000_0001, 4'd1}, // R1 run only
        {3'd1, 32'h0000_1234, 3'd1, 32'h0000_0ABC, 4'd4}, // R4 write while running ignored
        {3'd0, 32'h0000_0000, 3'd0, 32'h0000_0000, 4'd1}, // R1 stop
        {3'd1, 32'h0000_55AA, 3'd1, 32'h0000_55AA, 4'd4}, // R4
        {3'd2, 32'h0000_1000, 3'd2, 32'h0000_1000, 4'd1}, // R1 A pointer
        {3'd3, 32'h0000_0030, 3'd3, 32'h0000_0030, 4'd1}, // R1 A count
        {3'd4, 32'h0000_2000, 3'd4, 32'h0000_2000, 4'd1}, // R1 B pointer
        {3'd5, 32'h0000_0020, 3'd5, 32'h0000_0020, 4'd1}  // R1 B count
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int base;
        rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        dreq = 1'b0; ack_en = 1'b1; err_inj = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // Reset state (R1, R5)
        rd_chk("R1 reset control word", 3'd0, 32'h0);
        chk("R5 reset irq", 32'(irq), 32'h0);
        chk("R2 reset mem_req", 32'(mem_req), 32'h0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][73:71], VEC[i][70:39]);
            rd_chk($sformatf("R%0d table row %0d", VEC[i][3:0], i), VEC[i][38:36], VEC[i][35:4]);
        end
        chk("R4 mem_dev port", mem_dev, 32'h55AA);

        // R2: start bits with run clear do nothing, even with dreq high
        dreq = 1'b1;
        base = log_n;
        wr(3'd0, 32'h50);
        wait_cyc(6);
        chk("R2 no burst while stopped", 32'(log_n - base), 32'h0);
        rd_chk("R2 start bits ignored", 3'd0, 32'h0);

        // Main: A (3 bursts) chained into B (2 bursts)
        base = log_n;
        wr(3'd0, 32'h53);
        wait_cyc(20);
        chk("R8 burst count", 32'(log_n - base), 32'd5);
        chk("R8 burst 0 addr", log_addr[base],   32'h1000);
        chk("R8 burst 1 addr", log_addr[base+1], 32'h1010);
        chk("R8 burst 2 addr", log_addr[base+2], 32'h1020);
        chk("R9 burst 3 addr", log_addr[base+3], 32'h2000);
        chk("R9 burst 4 addr", log_addr[base+4], 32'h2010);
        chk("R8 full burst len", 32'(log_len[base]), 32'd16);
        chk("R9 spacing inside A", 32'(log_cyc[base+1] - log_cyc[base]), 32'd2);
        chk("R9 spacing across A to B", 32'(log_cyc[base+3] - log_cyc[base+2]), 32'd2);
        rd_chk("R10 both done, starts cleared, select back to A", 3'd0, 32'h2B);
        rd_chk("R8 A pointer advanced", 3'd2, 32'h1030);
        rd_chk("R8 A count zero", 3'd3, 32'h0);
        rd_chk("R8 B pointer advanced", 3'd4, 32'h2020);
        chk("R5 irq on done", 32'(irq), 32'h1);

        // R5 gating and R7 write-1-to-clear
        wr(3'd0, 32'h01);
        rd_chk("R5 enable off", 3'd0, 32'h29);
        chk("R5 irq masked", 32'(irq), 32'h0);
        wr(3'd0, 32'h03);
        @(negedge clk); #1;
        chk("R5 irq unmasked", 32'(irq), 32'h1);
        wr(3'd0, 32'h0B);
        rd_chk("R7 clear A done", 3'd0, 32'h23);
        chk("R5 irq with B done", 32'(irq), 32'h1);
        wr(3'd0, 32'h23);
        rd_chk("R7 clear B done", 3'd0, 32'h03);
        chk("R5 irq none pending", 32'(irq), 32'h0);

        // Alternation and waiting (R9, R10, R7, R8 short burst)
        wr(3'd2, 32'h3000);
        wr(3'd3, 32'h18);
        base = log_n;
        wr(3'd0, 32'h13);
        wait_cyc(12);
        chk("R8 short tail length", 32'(log_len[base+1]), 32'd8);
        chk("R8 tail addr", log_addr[base+1], 32'h3010);
        rd_chk("R8 select toggled to B", 3'd0, 32'h8B);
        rd_chk("R8 A pointer after tail", 3'd2, 32'h3018);
        base = log_n;
        wr(3'd0, 32'h13);
        wait_cyc(8);
        rd_chk("R10 A armed but waits for B turn; R7 done cleared", 3'd0, 32'h93);
        chk("R9 no burst while B unarmed", 32'(log_n - base), 32'h0);
        wr(3'd2, 32'h5000);
        wr(3'd3, 32'h10);
        wr(3'd4, 32'h4000);
        wr(3'd5, 32'h10);
        wr(3'd0, 32'h43);
        wait_cyc(12);
        chk("R9 B first", log_addr[base], 32'h4000);
        chk("R9 then A", log_addr[base+1], 32'h5000);
        rd_chk("R9 final state", 3'd0, 32'hAB);

        // Pause mid-burst on B (R3)
        wr(3'd0, 32'h2B);
        rd_chk("R7 both cleared", 3'd0, 32'h83);
        wr(3'd4, 32'h6000);
        wr(3'd5, 32'h30);
        ack_en = 1'b0;
        base = log_n;
        wr(3'd0, 32'h43);
        for (int k = 0; k < 10 && !mem_req; k++) @(negedge clk);
        chk("R8 B burst address", mem_addr, 32'h6000);
        wr(3'd0, 32'h02);
        chk("R3 request held after run cleared", 32'(mem_req), 32'h1);
        ack_en = 1'b1;
        wait_cyc(8);
        chk("R3 only the pending burst finished", 32'(log_n - base), 32'd1);
        rd_chk("R3 B pointer saved", 3'd4, 32'h6010);
        rd_chk("R3 B count saved", 3'd5, 32'h20);
        rd_chk("R3 paused control word", 3'd0, 32'h82);
        wr(3'd0, 32'h03);
        wait_cyc(10);
        chk("R3 resume addr", log_addr[base+1], 32'h6010);
        chk("R3 resume second addr", log_addr[base+2], 32'h6020);
        rd_chk("R3 resumed to completion", 3'd0, 32'h23);

        // Memory error on A (R6), dreq gating (R11)
        wr(3'd0, 32'h23);
        wr(3'd2, 32'h7000);
        wr(3'd3, 32'h20);
        err_inj = 1'b1;
        base = log_n;
        wr(3'd0, 32'h13);
        wait_cyc(6);
        rd_chk("R6 error captured", 3'd0, 32'h07);
        chk("R6 irq on error", 32'(irq), 32'h1);
        chk("R6 no completed burst", 32'(log_n - base), 32'h0);
        chk("R6 stopped issuing", 32'(mem_req), 32'h0);
        rd_chk("R6 pointer kept", 3'd2, 32'h7000);
        rd_chk("R6 count kept", 3'd3, 32'h20);
        err_inj = 1'b0;
        dreq = 1'b0;
        wr(3'd0, 32'h03);
        rd_chk("R6 error cleared by run", 3'd0, 32'h03);
        wait_cyc(5);
        chk("R11 no burst without dreq", 32'(log_n - base), 32'h0);
        dreq = 1'b1;
        wait_cyc(10);
        chk("R6 retry addr", log_addr[base], 32'h7000);
        chk("R11 bursts after dreq", 32'(log_n - base), 32'd2);
        rd_chk("R6 retry completes", 3'd0, 32'h8B);

        summary();
        $finish;
    end

endmodule